// File: doc/BRIEF.md
# Multi-Peripheral Reset Stage Sequencer

This block runs the reset stage of a small controller whose progress is held in a 3-bit stage register. The register lives inside the block. The stage code 000 is the reset stage. Whenever the register enters that code, whether after a chip reset or because another stage wrote it back, the block raises a single-cycle start pulse. The pulse is forwarded only to the peripheral initialisation engines whose enable input is high. There are three engines: a DAC, an ADC and a network controller.

The block then waits until every enabled engine reports completion. Disabled engines are treated as already complete. When that happens, the block emits a one-cycle done pulse. On the same cycle it presents 001 as the next stage code, and it uses the pulse as the write enable of its own stage register. Done levels left over from an earlier visit cannot end a visit, because completion is only watched after the start pulse of the current visit. Other stages of the controller load the register through a separate write port.

Top module: `rst_stage_seq`

## Requirements
- R1: While `rst_n` is low, `state_q` is 000 (applied asynchronously), `periph_go` is 0 and `stage_done` is 0. Reset is released internally through two flops, so the first start pulse is high in the cycle after the third rising edge that follows the release.
- R2: Each entry into stage 000 gives exactly one start-pulse cycle. The pulse is high in the cycle after the first cycle in which `state_q` reads 000. There is no start pulse in any other stage, and there are never two pulse cycles in a row.
- R3: `periph_go[i]` is the start pulse ANDed with `periph_en[i]`. Bit 0 is the DAC, bit 1 the ADC and bit 2 the network controller.
- R4: `stage_done` never rises in a visit before that visit's start pulse. Done levels held over from an earlier visit do not shorten the wait.
- R5: `stage_done` is high in the first cycle, at least one cycle after the start pulse, in which `periph_done[i]` is high for every enabled i. The done input of a disabled peripheral has no effect.
- R6: `stage_done` is a single-cycle pulse, and it occurs once per visit.
- R7: `next_state` is 001 while `stage_done` is high. Otherwise it equals `state_q`.
- R8: `stage_done` writes 001 into the stage register at the next rising edge. It wins over `other_wr_en` in the same cycle.
- R9: When `stage_done` is low, `other_wr_en` loads `other_wr_state` into the stage register at the next rising edge. When both are low, the register holds its value.
- R10: With all three enables low, `stage_done` pulses in the cycle right after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| other_wr_en | input | 1 | Stage register write from other stages |
| other_wr_state | input | 3 | Stage code written by other stages |
| periph_en | input | 3 | Per-peripheral enable (0 DAC, 1 ADC, 2 network) |
| periph_done | input | 3 | Per-peripheral initialisation complete level |
| periph_go | output | 3 | Per-peripheral start pulse |
| stage_done | output | 1 | One-cycle stage completion pulse |
| next_state | output | 3 | Stage code offered to the register |
| state_q | output | 3 | Current stage code |

## Verification
Internal faults in this block show up at the ports, and each kind shows up at a known cycle:

- A stuck or missed armed flag lets `stage_done` fire too early, on stale done levels. It shows up within one or two cycles of the start pulse, and `state_q` jumps to 001 early.
- A broken edge detector either repeats start pulses or never raises them. This is visible in the cycle after the register reads 000, and a missing pulse also stalls the stage.
- A wrong completion mask ends the stage at the wrong cycle compared with the slowest enabled engine. Because each visit's cycle count is predicted exactly, any error appears in that same visit.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned STW = 3;
  typedef logic [STW-1:0] stage_t;
  localparam stage_t STAGE_RESET = stage_t'(0);
  localparam stage_t STAGE_AFTER = stage_t'(1);
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rst_seq_state_reg.sv
module rst_seq_state_reg
  import rst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  stage_t wr_val,
  output stage_t q
);
  stage_t q_d;
  stage_t q_r;

  always_comb begin
    q_d = q_r;
    if (wr_en) q_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= STAGE_RESET;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/rst_seq_go_gen.sv
module rst_seq_go_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic stage_en,
  output logic go
);
  logic en_d_q, go_q;
  logic en_d_n, go_n;

  always_comb begin
    en_d_n = stage_en;
    go_n   = stage_en & ~en_d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      en_d_q <= en_d_n;
      go_q   <= go_n;
    end
  end

  assign go = go_q;
endmodule

// File: rtl/rst_seq_join.sv
module rst_seq_join #(
  parameter int unsigned NPER = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stage_en,
  input  logic            go,
  input  logic [NPER-1:0] en,
  input  logic [NPER-1:0] pdone,
  output logic            done
);
  logic            armed_q, qual_d_q;
  logic            armed_n, qual;
  logic [NPER-1:0] ok_vec;
  logic            flag;

  genvar gi;
  generate
    for (gi = 0; gi < NPER; gi++) begin : g_mask
      assign ok_vec[gi] = pdone[gi] | ~en[gi];
    end
  endgenerate

  always_comb begin
    flag    = &ok_vec;
    qual    = armed_q & flag;
    done    = qual & ~qual_d_q;
    armed_n = stage_en & ~done & (armed_q | go);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      qual_d_q <= 1'b0;
    end else begin
      armed_q  <= armed_n;
      qual_d_q <= qual;
    end
  end
endmodule

// File: rtl/rst_stage_seq.sv
module rst_stage_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned NPER = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            other_wr_en,
  input  logic [STW-1:0]  other_wr_state,
  input  logic [NPER-1:0] periph_en,
  input  logic [NPER-1:0] periph_done,
  output logic [NPER-1:0] periph_go,
  output logic            stage_done,
  output logic [STW-1:0]  next_state,
  output logic [STW-1:0]  state_q
);
  logic   srst_n;
  logic   stage_en;
  logic   go;
  logic   reg_wr;
  stage_t reg_val;
  stage_t cur;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  rst_seq_state_reg i_state (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_val(reg_val), .q(cur)
  );

  assign stage_en = (cur == STAGE_RESET);

  rst_seq_go_gen i_go (
    .clk(clk), .rst_n(srst_n), .stage_en(stage_en), .go(go)
  );

  rst_seq_join #(.NPER(NPER)) i_join (
    .clk(clk), .rst_n(srst_n), .stage_en(stage_en), .go(go),
    .en(periph_en), .pdone(periph_done), .done(stage_done)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NPER; gi++) begin : g_go
      assign periph_go[gi] = go & periph_en[gi];
    end
  endgenerate

  always_comb begin
    reg_wr  = stage_done | other_wr_en;
    reg_val = stage_done ? STAGE_AFTER : stage_t'(other_wr_state);
  end

  assign next_state = stage_done ? STAGE_AFTER : cur;
  assign state_q    = cur;
endmodule

// File: rtl/rst_stage_seq_checks.sv
module rst_stage_seq_checks #(
  parameter int unsigned NPER = 3,
  parameter int unsigned STW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            other_wr_en,
  input logic [STW-1:0]  other_wr_state,
  input logic [NPER-1:0] periph_en,
  input logic [NPER-1:0] periph_done,
  input logic [NPER-1:0] periph_go,
  input logic            stage_done,
  input logic [STW-1:0]  next_state,
  input logic [STW-1:0]  state_q
);
  logic seen_go_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_go_q <= 1'b0;
    else if (stage_done) seen_go_q <= 1'b0;
    else if (|periph_go || (periph_en == '0 && state_q == '0 && !seen_go_q && !stage_done))
      seen_go_q <= seen_go_q | (|periph_go);
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (state_q == '0 && periph_go == '0 && !stage_done));
  assert_go_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_go) |-> (state_q == '0));
  assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_go) |=> (periph_go == '0));
  assert_go_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_go & ~periph_en) == '0);
  assert_after_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_done && periph_en != '0) |-> seen_go_q);
  assert_join_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> ((periph_done | ~periph_en) == '1));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |=> !stage_done);
  assert_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> (next_state == STW'(1)));
  assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |=> (state_q == STW'(1)));
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr_en && !stage_done) |=> (state_q == $past(other_wr_state)));
endmodule

bind rst_stage_seq rst_stage_seq_checks #(.NPER(NPER), .STW(rst_seq_pkg::STW)) i_checks (
  .clk(clk), .rst_n(rst_n), .other_wr_en(other_wr_en), .other_wr_state(other_wr_state),
  .periph_en(periph_en), .periph_done(periph_done), .periph_go(periph_go),
  .stage_done(stage_done), .next_state(next_state), .state_q(state_q)
);

// File: tb/test_rst_stage_seq.sv
`timescale 1ns/1ps
module test_rst_stage_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       other_wr_en;
  logic [2:0] other_wr_state;
  logic [2:0] periph_en;
  logic [2:0] periph_done;
  logic [2:0] periph_go;
  logic       stage_done;
  logic [2:0] next_state;
  logic [2:0] state_q;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  int dly [3];
  logic [2:0] resp_done;
  logic [2:0] junk;
  int cnt [3];

  always #2 clk = ~clk;

  rst_stage_seq i_rst_stage_seq (
    .clk(clk), .rst_n(rst_n), .other_wr_en(other_wr_en), .other_wr_state(other_wr_state),
    .periph_en(periph_en), .periph_done(periph_done), .periph_go(periph_go),
    .stage_done(stage_done), .next_state(next_state), .state_q(state_q)
  );

  // Engine models: done falls on own go, rises dly cycles after the go cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_done <= '0;
      for (int i = 0; i < 3; i++) cnt[i] <= 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (periph_go[i]) begin
          resp_done[i] <= (dly[i] == 1);
          cnt[i]       <= dly[i] - 1;
        end else if (cnt[i] > 0) begin
          cnt[i] <= cnt[i] - 1;
          if (cnt[i] == 1) resp_done[i] <= 1'b1;
        end
      end
    end
  end

  assign periph_done = (resp_done & periph_en) | (junk & ~periph_en);

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int wait_cycles(input logic [2:0] e, input int d0, input int d1, input int d2);
    int m = 1;
    if (e[0] && d0 > m) m = d0;
    if (e[1] && d1 > m) m = d1;
    if (e[2] && d2 > m) m = d2;
    return m;
  endfunction

  // Walk from go cycle to done cycle, checking every cycle in between
  task automatic follow(input logic [2:0] e, input bit collide);
    int kexp = wait_cycles(e, dly[0], dly[1], dly[2]);
    for (int k = 1; k <= kexp; k++) begin
      @(negedge clk);
      if (k < kexp) begin
        chk(!stage_done, "R4/R5 early done", stage_done, 0);
        chk(periph_go == 0, "R2 repeat go", periph_go, 0);
      end else begin
        chk(stage_done, (e == 0) ? "R10 done after go" : "R5 done timing", stage_done, 1);
        chk(next_state == 3'd1, "R7 next_state", next_state, 1);
        if (collide) begin
          other_wr_en = 1'b1;
          other_wr_state = 3'd5;
        end
      end
    end
    @(negedge clk);
    other_wr_en = 1'b0;
    chk(state_q == 3'd1, "R8 state write", state_q, 1);
    chk(!stage_done, "R6 single done", stage_done, 0);
    chk(next_state == state_q, "R7 next_state idle", next_state, state_q);
  endtask

  task automatic visit(input logic [2:0] e, input int d0, input int d1, input int d2,
                       input bit collide);
    periph_en = e;
    dly[0] = d0; dly[1] = d1; dly[2] = d2;
    junk = 3'($urandom);
    other_wr_en = 1'b1;
    other_wr_state = 3'd0;
    @(negedge clk);
    other_wr_en = 1'b0;
    chk(state_q == 3'd0, "R9 load 000", state_q, 0);
    chk(periph_go == 0, "R2 go delay", periph_go, 0);
    chk(!stage_done, "R4 no done before go", stage_done, 0);
    @(negedge clk);
    chk(periph_go == e, "R3 go mask", periph_go, e);
    chk(!stage_done || e == 0 && 1'b0, "R4 done with go", stage_done, 0);
    follow(e, collide);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    other_wr_en = 1'b0;
    other_wr_state = 3'd0;
    periph_en = 3'b111;
    junk = 3'b000;
    dly[0] = 3; dly[1] = 2; dly[2] = 4;
    repeat (3) @(negedge clk);
    chk(state_q == 0, "R1 reset state", state_q, 0);
    chk(periph_go == 0 && !stage_done, "R1 reset outputs", {periph_go, stage_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(periph_go == 0, "R1 sync release", periph_go, 0);
    @(negedge clk);
    chk(periph_go == 3'b111, "R1 first go", periph_go, 7);
    follow(3'b111, 1'b0);

    // park in another stage: no go, value held
    other_wr_en = 1'b1; other_wr_state = 3'd6;
    @(negedge clk);
    other_wr_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(periph_go == 0 && !stage_done, "R2 no go outside 000", periph_go, 0);
      chk(state_q == 3'd6, "R9 hold", state_q, 6);
    end
    other_wr_en = 1'b1; other_wr_state = 3'd1;
    @(negedge clk);

    // directed corners
    visit(3'b000, 1, 1, 1, 1'b0);         // R10
    visit(3'b001, 20, 1, 1, 1'b0);        // stale done on slow DAC, R4
    visit(3'b110, 1, 1, 1, 1'b1);         // fastest, collision R8
    visit(3'b010, 1, 9, 1, 1'b0);
    visit(3'b100, 1, 1, 2, 1'b1);

    for (int n = 0; n < 40; n++) begin
      visit(3'($urandom), 1 + ($urandom % 12), 1 + ($urandom % 12), 1 + ($urandom % 12),
            1'($urandom));
    end

    // async reset mid-visit
    periph_en = 3'b011; dly[0] = 30; dly[1] = 30;
    other_wr_en = 1'b1; other_wr_state = 3'd0;
    @(negedge clk);
    other_wr_en = 1'b0;
    repeat (4) @(negedge clk);
    other_wr_en = 1'b1; other_wr_state = 3'd3;
    @(negedge clk);
    other_wr_en = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    chk(state_q == 0, "R1 async reset", state_q, 0);
    chk(periph_go == 0 && !stage_done, "R1 async outputs", {periph_go, stage_done}, 0);
    @(negedge clk);
    periph_en = 3'b000;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!stage_done, "R4 no done before go", stage_done, 0);
    @(negedge clk);
    chk(periph_go == 0, "R3 masked go", periph_go, 0);
    follow(3'b000, 1'b0);

    finish_run();
  end
endmodule